// File: doc/BRIEF.md
# FFT Stage Commutator and Reorder Buffer

This block sits between two stages of a pipelined FFT. The earlier stage delivers its results four samples per beat, in natural order. The block gathers a complete block of L samples. It then hands the next stage one four-point group per cycle: the four samples that lie a quarter of the block apart. Each group comes out on four parallel output lanes together with the matching twiddle-table addresses.

Storage is split into four quarter stores, one for each output lane, and each store holds two banks. Incoming beats fill one bank while the previous block drains from the other. The downstream stage paces the reads with a ready input. A beat that arrives while both banks hold unread blocks is refused and flagged. Each group also carries the bit-reversed form of its group index, which a final stage uses as the address in its output memory.

Top module: `fft_commutator`

## Requirements
- R1: While reset is held, and after it until a full block has been written, out_valid is low. ovf is low whenever in_valid is low. A block of L samples arrives over L/4 accepted beats, and beat c carries sample 4c+i on in_lane[i].
- R2: Group k of a block (k = 0 .. L/4-1) presents sample k on out_lane[0], sample k+L/2 on out_lane[1], sample k+L/4 on out_lane[2] and sample k+3L/4 on out_lane[3].
- R3: Within a block, groups leave in increasing k. Blocks leave in the order they were accepted, and every accepted block is delivered in full.
- R4: With each group, tw_a equals k*(TBL/L) and tw_b equals 3k*(TBL/L), where TBL is the twiddle table length.
- R5: With each group, out_rev equals k with its log2(L) bits reversed (bit 0 swapped with the top bit, and so on).
- R6: When a block's last beat is accepted at edge E and nx_ready is high, out_valid is still low between E and E+1 and is high after E+1.
- R7: out_valid is high in a cycle only if nx_ready was high in the cycle before. While nx_ready stays low, no group leaves.
- R8: With nx_ready high, input at one beat per cycle with no gaps never raises ovf, because one bank is written while the other is read.
- R9: A beat that arrives while both banks hold unread blocks raises ovf in the same cycle. It is not stored and does not advance the write position, so the next block that is accepted is reordered correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An input beat is present |
| in_lane | input | 4 x DW | Four consecutive samples; lane i holds sample 4c+i |
| nx_ready | input | 1 | The next stage can take a group this cycle |
| ovf | output | 1 | The beat present now is refused because both banks are full |
| out_valid | output | 1 | A four-point group is present on the outputs |
| out_lane | output | 4 x DW | Four-point group, spaced a quarter block apart |
| tw_a | output | log2(TBL) | First twiddle address, k*(TBL/L) |
| tw_b | output | log2(TBL) | Second twiddle address, 3k*(TBL/L) |
| out_rev | output | log2(L) | Group index k, bit-reversed |

## Verification
The bench builds the block with L = 32, DW = 12 and TBL = 512. At these values a block takes eight beats and each quarter store spans two write beats, so the beat-to-slot mapping is exercised inside each quarter. The twiddle scale of 16 and the five-bit reversal stay small enough to check in full. The short block lets both banks fill within a few dozen cycles, so the refusal path and the recovery after it are reached quickly. Gapped input combined with a toggling ready input reaches the states where writes and reads of the two banks interleave.

// File: rtl/fftc_pkg.sv
package fftc_pkg;
  localparam int LANES = 4;

  // output lane j is fed by quarter store {j[0], j[1]}:
  // lane0<-q0, lane1<-q2, lane2<-q1, lane3<-q3
  function automatic int quarter_of_lane(input int j);
    return ((j & 1) << 1) | ((j >> 1) & 1);
  endfunction
endpackage

// File: rtl/fftc_qstore.sv
module fftc_qstore #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = AW - 2
) (
  input  logic                                 clk,
  input  logic                                 we,
  input  logic                                 wbank,
  input  logic [BW-1:0]                        wbeat,
  input  logic [fftc_pkg::LANES-1:0][DW-1:0]   wdata,
  input  logic                                 rbank,
  input  logic [AW-1:0]                        raddr,
  output logic [DW-1:0]                        rdata
);
  // two banks of one quarter; a beat fills four adjacent slots
  logic [DW-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < fftc_pkg::LANES; i++) begin
        mem[{wbank, wbeat, 2'(i)}] <= wdata[i];
      end
    end
  end

  assign rdata = mem[{rbank, raddr}];
endmodule

// File: rtl/fftc_ctrl.sv
module fftc_ctrl #(
  parameter int GRPS = 16,
  localparam int KW  = $clog2(GRPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          nx_ready,
  output logic          wr_fire,
  output logic          wr_bank,
  output logic [KW-1:0] wr_cnt,
  output logic          rd_fire,
  output logic          rd_bank,
  output logic [KW-1:0] rd_cnt,
  output logic          ovf
);
  logic [1:0]    full_q, full_d;
  logic          wr_bank_q, wr_bank_d, rd_bank_q, rd_bank_d;
  logic [KW-1:0] wr_cnt_q, wr_cnt_d, rd_cnt_q, rd_cnt_d;
  logic          wr_last, rd_last;

  always_comb begin
    wr_fire   = in_valid && !full_q[wr_bank_q];
    ovf       = in_valid &&  full_q[wr_bank_q];
    rd_fire   = nx_ready &&  full_q[rd_bank_q];
    wr_last   = wr_fire && (wr_cnt_q == KW'(GRPS - 1));
    rd_last   = rd_fire && (rd_cnt_q == KW'(GRPS - 1));
    full_d    = full_q;
    if (wr_last) full_d[wr_bank_q] = 1'b1;
    if (rd_last) full_d[rd_bank_q] = 1'b0;
    wr_cnt_d  = wr_fire ? wr_cnt_q + KW'(1) : wr_cnt_q;
    rd_cnt_d  = rd_fire ? rd_cnt_q + KW'(1) : rd_cnt_q;
    wr_bank_d = wr_bank_q ^ wr_last;
    rd_bank_d = rd_bank_q ^ rd_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      wr_cnt_q  <= '0;
      rd_cnt_q  <= '0;
    end else begin
      full_q    <= full_d;
      wr_bank_q <= wr_bank_d;
      rd_bank_q <= rd_bank_d;
      wr_cnt_q  <= wr_cnt_d;
      rd_cnt_q  <= rd_cnt_d;
    end
  end

  assign wr_bank = wr_bank_q;
  assign wr_cnt  = wr_cnt_q;
  assign rd_bank = rd_bank_q;
  assign rd_cnt  = rd_cnt_q;

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ($stable(wr_cnt_q) && $stable(wr_bank_q)));
endmodule

// File: rtl/fftc_twgen.sv
module fftc_twgen #(
  parameter int L    = 64,
  parameter int TBL  = 512,
  localparam int KW  = $clog2(L / 4),
  localparam int TAW = $clog2(TBL),
  localparam int LW  = $clog2(L),
  localparam int SH  = $clog2(TBL / L)
) (
  input  logic [KW-1:0]  k,
  output logic [TAW-1:0] tw_a,
  output logic [TAW-1:0] tw_b,
  output logic [LW-1:0]  rev
);
  logic [TAW-1:0] kx;
  logic [LW-1:0]  kl;

  always_comb begin
    kx   = TAW'(k);
    kl   = LW'(k);
    tw_a = kx << SH;
    tw_b = (kx + (kx << 1)) << SH;
    for (int i = 0; i < LW; i++) rev[i] = kl[LW-1-i];
  end
endmodule

// File: rtl/fft_commutator.sv
module fft_commutator #(
  parameter int DW   = 16,
  parameter int L    = 64,
  parameter int TBL  = 512,
  localparam int GRPS = L / 4,
  localparam int KW   = $clog2(GRPS),
  localparam int TAW  = $clog2(TBL),
  localparam int LW   = $clog2(L),
  localparam int SCALE = TBL / L
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [fftc_pkg::LANES-1:0][DW-1:0]  in_lane,
  input  logic                                nx_ready,
  output logic                                ovf,
  output logic                                out_valid,
  output logic [fftc_pkg::LANES-1:0][DW-1:0]  out_lane,
  output logic [TAW-1:0]                      tw_a,
  output logic [TAW-1:0]                      tw_b,
  output logic [LW-1:0]                       out_rev
);
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic          wr_fire, wr_bank, rd_fire, rd_bank;
  logic [KW-1:0] wr_cnt, rd_cnt;

  fftc_ctrl #(.GRPS(GRPS)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .in_valid(in_valid), .nx_ready(nx_ready),
    .wr_fire(wr_fire), .wr_bank(wr_bank), .wr_cnt(wr_cnt),
    .rd_fire(rd_fire), .rd_bank(rd_bank), .rd_cnt(rd_cnt), .ovf(ovf)
  );

  logic [fftc_pkg::LANES-1:0][DW-1:0] qdat, grp_d;

  for (genvar q = 0; q < fftc_pkg::LANES; q++) begin : g_quarter
    fftc_qstore #(.DW(DW), .DEPTH(GRPS)) u_qs (
      .clk(clk),
      .we(wr_fire && (wr_cnt[KW-1:KW-2] == 2'(q))),
      .wbank(wr_bank), .wbeat(wr_cnt[KW-3:0]), .wdata(in_lane),
      .rbank(rd_bank), .raddr(rd_cnt), .rdata(qdat[q])
    );
  end

  for (genvar j = 0; j < fftc_pkg::LANES; j++) begin : g_lane
    localparam int QS = fftc_pkg::quarter_of_lane(j);
    assign grp_d[j] = qdat[QS];
  end

  logic [TAW-1:0] tw_a_d, tw_b_d;
  logic [LW-1:0]  rev_d;

  fftc_twgen #(.L(L), .TBL(TBL)) u_tw (
    .k(rd_cnt), .tw_a(tw_a_d), .tw_b(tw_b_d), .rev(rev_d)
  );

  logic                               out_valid_q;
  logic [fftc_pkg::LANES-1:0][DW-1:0] out_lane_q;
  logic [TAW-1:0]                     tw_a_q, tw_b_q;
  logic [LW-1:0]                      out_rev_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_valid_q <= 1'b0;
    else          out_valid_q <= rd_fire;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) begin
      out_lane_q <= grp_d;
      tw_a_q     <= tw_a_d;
      tw_b_q     <= tw_b_d;
      out_rev_q  <= rev_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_lane  = out_lane_q;
  assign tw_a      = tw_a_q;
  assign tw_b      = tw_b_q;
  assign out_rev   = out_rev_q;

  // R7
  rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid_q |-> $past(nx_ready));

  // R4
  tw_ratio_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid_q |-> (tw_b_q == TAW'(TAW'(3) * tw_a_q)));

  // R3
  grp_step_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid_q && $past(out_valid_q) && (tw_a_q != '0))
      |-> (tw_a_q == TAW'($past(tw_a_q) + TAW'(SCALE))));
endmodule

// File: tb/sim_fft_commutator.sv
`timescale 1ns/1ps
module sim_fft_commutator;
  localparam int DW  = 12;
  localparam int L   = 32;
  localparam int TBL = 512;
  localparam int G   = L / 4;
  localparam int TAW = 9;
  localparam int LW  = 5;
  localparam int SC  = TBL / L;
  localparam int EW  = 4 * DW + 2 * TAW + LW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n, in_valid, nx_ready;
  logic [3:0][DW-1:0]   in_lane;
  logic                 ovf, out_valid;
  logic [3:0][DW-1:0]   out_lane;
  logic [TAW-1:0]       tw_a, tw_b;
  logic [LW-1:0]        out_rev;

  fft_commutator #(.DW(DW), .L(L), .TBL(TBL)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lane(in_lane),
    .nx_ready(nx_ready), .ovf(ovf), .out_valid(out_valid), .out_lane(out_lane),
    .tw_a(tw_a), .tw_b(tw_b), .out_rev(out_rev)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [EW-1:0] expq[$];

  task automatic chk(input bit ok, input string tag,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(input int blk, input int s);
    return DW'(blk * 64 + s);
  endfunction

  function automatic logic [EW-1:0] exp_item(input int blk, input int k);
    logic [LW-1:0] kk, rv;
    kk = LW'(k);
    for (int b = 0; b < LW; b++) rv[b] = kk[LW-1-b];
    return {val(blk, k + 3*L/4), val(blk, k + L/4), val(blk, k + L/2), val(blk, k),
            TAW'(k * SC), TAW'(3 * k * SC), rv};
  endfunction

  // monitor: pops expected groups as the design releases them (R2 R3 R4 R5)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [EW-1:0] got, e;
      got = {out_lane[3], out_lane[2], out_lane[1], out_lane[0], tw_a, tw_b, out_rev};
      if (expq.size() == 0) chk(1'b0, "R3 group with none pending", got, '0);
      else begin
        e = expq.pop_front();
        chk(got == e, "R2 R4 R5 group content/order", got, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // driver: pushes the expected groups, then drives the block's beats
  task automatic send_block(input int blk, input int gap);
    for (int k = 0; k < G; k++) expq.push_back(exp_item(blk, k));
    for (int c = 0; c < G; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int i = 0; i < 4; i++) in_lane[i] = val(blk, 4*c + i);
      #1;
      chk(ovf == 1'b0, "R8 no refusal with a free bank", EW'(ovf), '0);
      if (gap > 0) idle(gap);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; nx_ready = 1'b0; in_lane = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && ovf == 1'b0, "R1 reset state", EW'({out_valid, ovf}), '0);
    rst_n = 1'b1;
    idle(4);

    // first block: latency and no early read (R1 R6)
    nx_ready = 1'b1;
    send_block(0, 0);
    chk(out_valid == 1'b0, "R1 no group before block complete", EW'(out_valid), '0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 one cycle before first group", EW'(out_valid), '0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 first group two edges after last beat", EW'(out_valid), 1);
    idle(G + 4);

    // continuous blocks, overlap of write and read (R8)
    send_block(1, 0);
    send_block(2, 0);
    send_block(3, 0);
    idle(2 * G + 4);

    // both banks full, stall and refusal (R7 R9)
    nx_ready = 1'b0;
    send_block(4, 0);
    send_block(5, 0);
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < 4; i++) in_lane[i] = val(99, i);
    #1;
    chk(ovf == 1'b1, "R9 beat refused when both banks full", EW'(ovf), 1);
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R7 no group while ready low", EW'(out_valid), '0);
    end
    nx_ready = 1'b1;
    idle(2 * G + 4);
    send_block(6, 0);   // R9 refused beat left write position untouched
    idle(G + 4);

    // gapped input with toggling ready (R3 R7)
    fork
      begin
        send_block(7, 1);
        send_block(8, 2);
      end
      begin
        repeat (40) begin
          @(negedge clk);
          nx_ready = ~nx_ready;
        end
      end
    join
    @(negedge clk);
    nx_ready = 1'b1;
    idle(3 * G + 4);

    chk(expq.size() == 0, "R3 every accepted block delivered", EW'(expq.size()), '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule